// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the register updates a processor control unit makes when it takes an exception. A single strobe carries the exception class, an optional cause code and coprocessor number, the faulting PC and the delay-slot flag, together with the current status, cause and debug register values and the debug-mode flag. On that clock edge the block works out which of three entry paths applies: general, error-level (reset, soft reset, NMI) or debug. It then loads the new program counter, the return-address register that belongs to that path, and the updated status, cause and debug words.

A registered write mask goes out for one cycle after the strobe. It tells the surrounding register file which outputs were written, and it also carries the side effects the block requests: clearing the watch-low register, clearing the in-delay-slot flag, and entering debug mode. Outputs that the chosen path does not touch keep their previous value.

Top module: `exc_entry`

## Requirements
- R1: After reset, `pc_o` equals the reset vector (0xBFC00000), every other data output is zero and `wr_o` is zero. Outputs hold their value while `exc_valid_i` is low. A strobe whose class code is 12 to 15 is ignored: no output changes and `wr_o` stays zero.
- R2: For a general entry, classes 0 (code from `exc_code_i`), 1 (coprocessor unusable) and 2 (external interrupt outside debug mode), `epc_o` becomes `pc_i` minus 4 when `in_dslot_i` is high, with 32-bit wraparound, and `pc_i` otherwise. Cause bit 31 is set to `in_dslot_i`.
- R3: A general entry loads `pc_o` with 0xBFC00200 when status bit 22 (boot vectors) is set, and with 0x80000000 when it is clear.
- R4: A general entry sets status bit 1 (exception level) and leaves the other status bits unchanged. It writes the 5-bit code into cause bits 6:2 and keeps the other cause bits, apart from bit 31.
- R5: Class 1 writes code 11 into cause bits 6:2, whatever `exc_code_i` holds, and writes `cop_i` into cause bits 29:28. The other general classes leave bits 29:28 unchanged.
- R6: Class 2 with `debug_mode_i` low is a general entry with code 0.
- R7: Classes 3 (reset), 4 (soft reset) and 5 (NMI) load `errorepc_o` using the delay-slot rule of R2. They set status bits 2 (error level) and 22 and load `pc_o` with 0xBFC00000.
- R8: Reset clears status bits 20 and 19 and keeps the others. Soft reset makes status exactly bits 20, 22 and 2, and raises `wr_o` bit 7 (clear watch-low). NMI makes status exactly bits 19, 22 and 2.
- R9: Debug classes 8 (instruction break), 9 (breakpoint), 10 (data store break) and 11 (data load break) load `depc_o` using the delay-slot rule. They load `pc_o` with 0xBFC00480 and raise `wr_o` bit 9 (enter debug mode). They OR debug bit 4, 1, 3 or 2 respectively into `debug_o`.
- R10: Class 6 (single step) is a debug entry that sets debug bit 0 and always saves `pc_i` in `depc_o`, whatever `in_dslot_i` holds.
- R11: Class 2 with `debug_mode_i` high, and class 7, are debug interrupts: a debug entry that sets debug bit 5.
- R12: `wr_o` is high for exactly the cycle after an accepted strobe. Its bits are: 0 pc, 1 epc, 2 errorepc, 3 depc, 4 status, 5 cause, 6 debug, 7 watch-low clear, 8 delay-slot clear, 9 debug-mode set. Exactly one return-register bit is set, and bit 8 is set on every accepted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception strobe |
| exc_class_i | input | 4 | Exception class code |
| exc_code_i | input | 5 | Cause code for class 0 |
| cop_i | input | 2 | Coprocessor number for class 1 |
| pc_i | input | 32 | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| debug_mode_i | input | 1 | Processor is in debug mode |
| status_i | input | 32 | Current status word |
| cause_i | input | 32 | Current cause word |
| debug_i | input | 32 | Current debug word |
| pc_o | output | 32 | New program counter |
| epc_o | output | 32 | General return address |
| errorepc_o | output | 32 | Error-level return address |
| depc_o | output | 32 | Debug return address |
| status_o | output | 32 | Updated status word |
| cause_o | output | 32 | Updated cause word |
| debug_o | output | 32 | Updated debug word |
| wr_o | output | 10 | One-cycle write and side-effect mask |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 4-byte instruction step and the standard vector addresses. With these values a delay-slot entry at PC 0 makes the return address wrap to 0xFFFFFFFC, and that corner is checked directly. Both settings of the boot-vector bit, every class code including the unused codes 12 to 15, and an external interrupt taken inside and outside debug mode are each driven. The bench compares the write mask and the untouched registers, as well as the written ones.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int REG_W  = 32;
  localparam int CODE_W = 5;
  localparam int DBG_N  = 6;

  typedef enum logic [3:0] {
    CLS_GEN  = 4'd0,  CLS_CPU  = 4'd1,  CLS_INT  = 4'd2,  CLS_RST  = 4'd3,
    CLS_SRST = 4'd4,  CLS_NMI  = 4'd5,  CLS_DSS  = 4'd6,  CLS_DINT = 4'd7,
    CLS_DIB  = 4'd8,  CLS_DBP  = 4'd9,  CLS_DDBS = 4'd10, CLS_DDBL = 4'd11
  } exc_class_e;

  typedef enum logic [1:0] {PATH_NONE, PATH_GEN, PATH_ERR, PATH_DBG} exc_path_e;
  typedef enum logic [1:0] {ERR_RST, ERR_SRST, ERR_NMI} err_kind_e;

  // status bit positions
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_NMI = 19;
  localparam int ST_SR  = 20;
  localparam int ST_BEV = 22;
  // cause fields
  localparam int CA_BD   = 31;
  localparam int CA_CE   = 28;
  localparam int CA_CODE = 2;
  // debug cause bits
  localparam int DB_SS  = 0;
  localparam int DB_BP  = 1;
  localparam int DB_DL  = 2;
  localparam int DB_DS  = 3;
  localparam int DB_IB  = 4;
  localparam int DB_INT = 5;
  // write mask bits
  localparam int WR_PC    = 0;
  localparam int WR_EPC   = 1;
  localparam int WR_ERR   = 2;
  localparam int WR_DEPC  = 3;
  localparam int WR_STAT  = 4;
  localparam int WR_CAUSE = 5;
  localparam int WR_DBG   = 6;
  localparam int WR_WCLR  = 7;
  localparam int WR_DSCLR = 8;
  localparam int WR_DM    = 9;
  localparam int WR_W     = 10;

  localparam logic [CODE_W-1:0] CODE_INT = 5'd0;
  localparam logic [CODE_W-1:0] CODE_CPU = 5'd11;

  typedef struct packed {
    exc_path_e         path;
    err_kind_e         err_kind;
    logic [CODE_W-1:0] code;
    logic              set_ce;
    logic              no_fix;
    logic [DBG_N-1:0]  dbg_bits;
  } exc_dec_t;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [3:0]        class_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              debug_mode_i,
  output exc_dec_t          dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.path     = PATH_NONE;
    dec_o.err_kind = ERR_RST;
    case (class_i)
      CLS_GEN: begin
        dec_o.path = PATH_GEN;
        dec_o.code = code_i;
      end
      CLS_CPU: begin
        dec_o.path   = PATH_GEN;
        dec_o.code   = CODE_CPU;
        dec_o.set_ce = 1'b1;
      end
      CLS_INT: begin
        if (debug_mode_i) begin
          dec_o.path           = PATH_DBG;
          dec_o.dbg_bits[DB_INT] = 1'b1;
        end else begin
          dec_o.path = PATH_GEN;
          dec_o.code = CODE_INT;
        end
      end
      CLS_RST: begin
        dec_o.path = PATH_ERR;
        dec_o.err_kind = ERR_RST;
      end
      CLS_SRST: begin
        dec_o.path = PATH_ERR;
        dec_o.err_kind = ERR_SRST;
      end
      CLS_NMI: begin
        dec_o.path = PATH_ERR;
        dec_o.err_kind = ERR_NMI;
      end
      CLS_DSS: begin
        dec_o.path            = PATH_DBG;
        dec_o.no_fix          = 1'b1;  // single step resumes at next insn
        dec_o.dbg_bits[DB_SS] = 1'b1;
      end
      CLS_DINT: begin
        dec_o.path = PATH_DBG;
        dec_o.dbg_bits[DB_INT] = 1'b1;
      end
      CLS_DIB: begin
        dec_o.path = PATH_DBG;
        dec_o.dbg_bits[DB_IB] = 1'b1;
      end
      CLS_DBP: begin
        dec_o.path = PATH_DBG;
        dec_o.dbg_bits[DB_BP] = 1'b1;
      end
      CLS_DDBS: begin
        dec_o.path = PATH_DBG;
        dec_o.dbg_bits[DB_DS] = 1'b1;
      end
      CLS_DDBL: begin
        dec_o.path = PATH_DBG;
        dec_o.dbg_bits[DB_DL] = 1'b1;
      end
      default: dec_o.path = PATH_NONE;
    endcase
  end
endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr #(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              in_dslot_i,
  input  logic              no_fix_i,
  output logic [ADDR_W-1:0] ret_o,
  output logic              bd_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  assign bd_o  = in_dslot_i & ~no_fix_i;
  // return to the branch when the fault sits in its slot
  assign ret_o = bd_o ? (pc_i - STEP) : pc_i;
endmodule

// File: rtl/exc_cp0_next.sv
module exc_cp0_next
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_RST  = ADDR_W'(32'hBFC0_0000),
  parameter logic [ADDR_W-1:0] VEC_BOOT = ADDR_W'(32'hBFC0_0200),
  parameter logic [ADDR_W-1:0] VEC_NORM = ADDR_W'(32'h8000_0000),
  parameter logic [ADDR_W-1:0] VEC_DBG  = ADDR_W'(32'hBFC0_0480)
) (
  input  exc_path_e         path_i,
  input  err_kind_e         err_kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              set_ce_i,
  input  logic [DBG_N-1:0]  dbg_bits_i,
  input  logic              bd_i,
  input  logic [1:0]        cop_i,
  input  logic [REG_W-1:0]  status_i,
  input  logic [REG_W-1:0]  cause_i,
  input  logic [REG_W-1:0]  debug_i,
  output logic [REG_W-1:0]  status_o,
  output logic [REG_W-1:0]  cause_o,
  output logic [REG_W-1:0]  debug_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [WR_W-1:0]   wr_o
);
  logic [REG_W-1:0] dbg_set;

  genvar gi;
  generate
    for (gi = 0; gi < REG_W; gi++) begin : g_dbg
      if (gi < DBG_N) begin : g_src
        assign dbg_set[gi] = dbg_bits_i[gi];
      end else begin : g_zero
        assign dbg_set[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    status_o = status_i;
    cause_o  = cause_i;
    debug_o  = debug_i;
    vec_o    = '0;
    wr_o     = '0;
    unique case (path_i)
      PATH_GEN: begin
        status_o[ST_EXL]              = 1'b1;
        cause_o[CA_BD]                = bd_i;
        cause_o[CA_CODE +: CODE_W]    = code_i;
        if (set_ce_i) cause_o[CA_CE +: 2] = cop_i;
        vec_o = status_i[ST_BEV] ? VEC_BOOT : VEC_NORM;
        wr_o[WR_PC]    = 1'b1;
        wr_o[WR_EPC]   = 1'b1;
        wr_o[WR_STAT]  = 1'b1;
        wr_o[WR_CAUSE] = 1'b1;
        wr_o[WR_DSCLR] = 1'b1;
      end
      PATH_ERR: begin
        case (err_kind_i)
          ERR_SRST: begin
            status_o        = '0;
            status_o[ST_SR] = 1'b1;
            wr_o[WR_WCLR]   = 1'b1;
          end
          ERR_NMI: begin
            status_o         = '0;
            status_o[ST_NMI] = 1'b1;
          end
          default: begin
            status_o[ST_SR]  = 1'b0;
            status_o[ST_NMI] = 1'b0;
          end
        endcase
        status_o[ST_ERL] = 1'b1;
        status_o[ST_BEV] = 1'b1;
        vec_o = VEC_RST;
        wr_o[WR_PC]    = 1'b1;
        wr_o[WR_ERR]   = 1'b1;
        wr_o[WR_STAT]  = 1'b1;
        wr_o[WR_DSCLR] = 1'b1;
      end
      PATH_DBG: begin
        debug_o = debug_i | dbg_set;
        vec_o   = VEC_DBG;
        wr_o[WR_PC]    = 1'b1;
        wr_o[WR_DEPC]  = 1'b1;
        wr_o[WR_DBG]   = 1'b1;
        wr_o[WR_DSCLR] = 1'b1;
        wr_o[WR_DM]    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] VEC_RST    = ADDR_W'(32'hBFC0_0000),
  parameter logic [ADDR_W-1:0] VEC_BOOT   = ADDR_W'(32'hBFC0_0200),
  parameter logic [ADDR_W-1:0] VEC_NORM   = ADDR_W'(32'h8000_0000),
  parameter logic [ADDR_W-1:0] VEC_DBG    = ADDR_W'(32'hBFC0_0480)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [3:0]        exc_class_i,
  input  logic [4:0]        exc_code_i,
  input  logic [1:0]        cop_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              in_dslot_i,
  input  logic              debug_mode_i,
  input  logic [31:0]       status_i,
  input  logic [31:0]       cause_i,
  input  logic [31:0]       debug_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] epc_o,
  output logic [ADDR_W-1:0] errorepc_o,
  output logic [ADDR_W-1:0] depc_o,
  output logic [31:0]       status_o,
  output logic [31:0]       cause_o,
  output logic [31:0]       debug_o,
  output logic [9:0]        wr_o
);
  exc_dec_t          dec;
  logic [ADDR_W-1:0] ret_addr;
  logic              bd;
  logic [REG_W-1:0]  status_n, cause_n, debug_n;
  logic [ADDR_W-1:0] vec;
  logic [WR_W-1:0]   wr_n;
  logic              take;

  exc_classify u_cls (
    .class_i      (exc_class_i),
    .code_i       (exc_code_i),
    .debug_mode_i (debug_mode_i),
    .dec_o        (dec)
  );

  exc_retaddr #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_ret (
    .pc_i       (pc_i),
    .in_dslot_i (in_dslot_i),
    .no_fix_i   (dec.no_fix),
    .ret_o      (ret_addr),
    .bd_o       (bd)
  );

  exc_cp0_next #(
    .ADDR_W(ADDR_W), .VEC_RST(VEC_RST), .VEC_BOOT(VEC_BOOT),
    .VEC_NORM(VEC_NORM), .VEC_DBG(VEC_DBG)
  ) u_nxt (
    .path_i     (dec.path),
    .err_kind_i (dec.err_kind),
    .code_i     (dec.code),
    .set_ce_i   (dec.set_ce),
    .dbg_bits_i (dec.dbg_bits),
    .bd_i       (bd),
    .cop_i      (cop_i),
    .status_i   (status_i),
    .cause_i    (cause_i),
    .debug_i    (debug_i),
    .status_o   (status_n),
    .cause_o    (cause_n),
    .debug_o    (debug_n),
    .vec_o      (vec),
    .wr_o       (wr_n)
  );

  assign take = exc_valid_i && (dec.path != PATH_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o       <= VEC_RST;
      epc_o      <= '0;
      errorepc_o <= '0;
      depc_o     <= '0;
      status_o   <= '0;
      cause_o    <= '0;
      debug_o    <= '0;
      wr_o       <= '0;
    end else begin
      wr_o <= take ? wr_n : '0;
      if (take) begin
        pc_o <= vec;
        if (wr_n[WR_EPC])   epc_o      <= ret_addr;
        if (wr_n[WR_ERR])   errorepc_o <= ret_addr;
        if (wr_n[WR_DEPC])  depc_o     <= ret_addr;
        if (wr_n[WR_STAT])  status_o   <= status_n;
        if (wr_n[WR_CAUSE]) cause_o    <= cause_n;
        if (wr_n[WR_DBG])   debug_o    <= debug_n;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] VEC_RST    = ADDR_W'(32'hBFC0_0000),
  parameter logic [ADDR_W-1:0] VEC_BOOT   = ADDR_W'(32'hBFC0_0200),
  parameter logic [ADDR_W-1:0] VEC_NORM   = ADDR_W'(32'h8000_0000),
  parameter logic [ADDR_W-1:0] VEC_DBG    = ADDR_W'(32'hBFC0_0480)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exc_valid_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              in_dslot_i,
  input logic              bev_i,
  input logic              exl_o,
  input logic              erl_o,
  input logic              bev_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] epc_o,
  input logic [9:0]        wr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

  // R12
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(exc_valid_i) |-> wr_o == '0);
  // R12
  one_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o[WR_DEPC:WR_EPC]));
  // R12
  dsclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o != '0) |-> wr_o[WR_DSCLR]);
  // R2
  epc_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[WR_EPC] |-> epc_o == ($past(in_dslot_i) ? $past(pc_i) - STEP : $past(pc_i)));
  // R3
  gen_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[WR_EPC] |-> pc_o == ($past(bev_i) ? VEC_BOOT : VEC_NORM));
  // R4
  exl_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[WR_EPC] |-> exl_o);
  // R7
  err_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[WR_ERR] |-> (erl_o && bev_o && pc_o == VEC_RST));
  // R9
  dbg_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o[WR_DEPC] |-> (wr_o[WR_DM] && pc_o == VEC_DBG));
endmodule

bind exc_entry exc_entry_chk #(
  .ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES), .VEC_RST(VEC_RST),
  .VEC_BOOT(VEC_BOOT), .VEC_NORM(VEC_NORM), .VEC_DBG(VEC_DBG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .exc_valid_i (exc_valid_i),
  .pc_i        (pc_i),
  .in_dslot_i  (in_dslot_i),
  .bev_i       (status_i[22]),
  .exl_o       (status_o[1]),
  .erl_o       (status_o[2]),
  .bev_o       (status_o[22]),
  .pc_o        (pc_o),
  .epc_o       (epc_o),
  .wr_o        (wr_o)
);

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  cls = '0;
  logic [4:0]  code = '0;
  logic [1:0]  cop = '0;
  logic [31:0] pc = '0;
  logic        dslot = 1'b0;
  logic        dm = 1'b0;
  logic [31:0] st_i = '0, ca_i = '0, db_i = '0;
  logic [31:0] pc_o, epc_o, err_o, depc_o, st_o, ca_o, db_o;
  logic [9:0]  wr_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  exc_entry u_exc_entry (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(valid), .exc_class_i(cls),
    .exc_code_i(code), .cop_i(cop), .pc_i(pc), .in_dslot_i(dslot),
    .debug_mode_i(dm), .status_i(st_i), .cause_i(ca_i), .debug_i(db_i),
    .pc_o(pc_o), .epc_o(epc_o), .errorepc_o(err_o), .depc_o(depc_o),
    .status_o(st_o), .cause_o(ca_o), .debug_o(db_o), .wr_o(wr_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive one strobe, return after the update edge (at a negedge)
  task automatic fire(logic [3:0] c, logic [4:0] k, logic [1:0] cp, logic [31:0] p,
                      logic s, logic d, logic [31:0] st, logic [31:0] ca, logic [31:0] db);
    @(negedge clk);
    cls = c; code = k; cop = cp; pc = p; dslot = s; dm = d;
    st_i = st; ca_i = ca; db_i = db; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "pc after reset", pc_o, 32'hBFC0_0000);
    chk("R1", "epc after reset", epc_o, 0);
    chk("R1", "status after reset", st_o, 0);
    chk("R1", "wr after reset", {22'd0, wr_o}, 0);
  endtask

  task automatic t_gen_plain();
    fire(4'd0, 5'd5, 2'd0, 32'h0040_0100, 1'b0, 1'b0, 32'h0000_FF00, 32'h3000_0300, 0);
    chk("R2", "epc no slot", epc_o, 32'h0040_0100);
    chk("R2", "cause BD/code", ca_o, 32'h3000_0314);
    chk("R3", "normal vector", pc_o, 32'h8000_0000);
    chk("R4", "status EXL", st_o, 32'h0000_FF02);
    chk("R12", "wr mask general", {22'd0, wr_o}, 32'h133);
    @(negedge clk);
    chk("R12", "wr drops", {22'd0, wr_o}, 0);
  endtask

  task automatic t_gen_slot();
    fire(4'd0, 5'd8, 2'd0, 32'h0040_0200, 1'b1, 1'b0, 32'h0040_0000, 32'h0000_007C, 0);
    chk("R2", "epc in slot", epc_o, 32'h0040_01FC);
    chk("R2", "cause BD set", ca_o, 32'h8000_0020);
    chk("R3", "boot vector", pc_o, 32'hBFC0_0200);
    chk("R4", "status EXL keep BEV", st_o, 32'h0040_0002);
  endtask

  task automatic t_wrap();
    fire(4'd0, 5'd4, 2'd0, 32'h0, 1'b1, 1'b0, 0, 0, 0);
    chk("R2", "epc wrap", epc_o, 32'hFFFF_FFFC);
  endtask

  task automatic t_cpu();
    fire(4'd1, 5'd3, 2'd2, 32'h1234, 1'b0, 1'b0, 0, 32'h1000_0000, 0);
    chk("R5", "cause CE/code", ca_o, 32'h2000_002C);
    fire(4'd0, 5'd1, 2'd1, 32'h1234, 1'b0, 1'b0, 0, 32'h1000_0000, 0);
    chk("R5", "CE kept other class", ca_o, 32'h1000_0004);
  endtask

  task automatic t_int();
    logic [31:0] depc_b;
    depc_b = depc_o;
    fire(4'd2, 5'd9, 2'd0, 32'h5000, 1'b0, 1'b0, 0, 32'h0000_0044, 32'h0000_0001);
    chk("R6", "int code 0", ca_o, 0);
    chk("R6", "int epc", epc_o, 32'h5000);
    chk("R6", "int depc untouched", depc_o, depc_b);
  endtask

  task automatic t_int_dm();
    logic [31:0] epc_b;
    epc_b = epc_o;
    fire(4'd2, 5'd0, 2'd0, 32'h6000, 1'b1, 1'b1, 0, 0, 0);
    chk("R11", "dint bit", db_o, 32'h20);
    chk("R11", "dint depc", depc_o, 32'h5FFC);
    chk("R11", "dint vector", pc_o, 32'hBFC0_0480);
    chk("R11", "epc untouched", epc_o, epc_b);
    fire(4'd7, 5'd0, 2'd0, 32'h6100, 1'b0, 1'b0, 0, 0, 32'h1);
    chk("R11", "class7 bit", db_o, 32'h21);
  endtask

  task automatic t_err();
    fire(4'd3, 5'd0, 2'd0, 32'h1000, 1'b1, 1'b0, 32'h0018_0001, 0, 0);
    chk("R7", "reset errorepc", err_o, 32'h0FFC);
    chk("R7", "reset vector", pc_o, 32'hBFC0_0000);
    chk("R8", "reset status", st_o, 32'h0040_0005);
    chk("R12", "wr reset", {22'd0, wr_o}, 32'h115);
    fire(4'd4, 5'd0, 2'd0, 32'h2000, 1'b0, 1'b0, 32'hFFFF_FFFF, 0, 0);
    chk("R7", "soft errorepc", err_o, 32'h2000);
    chk("R8", "soft status", st_o, 32'h0050_0004);
    chk("R8", "soft watch clear", {22'd0, wr_o}, 32'h195);
    fire(4'd5, 5'd0, 2'd0, 32'h3000, 1'b1, 1'b0, 32'hFFFF_FFFF, 0, 0);
    chk("R7", "nmi errorepc", err_o, 32'h2FFC);
    chk("R8", "nmi status", st_o, 32'h0048_0004);
    chk("R8", "nmi no watch clear", {22'd0, wr_o}, 32'h115);
  endtask

  task automatic t_ss();
    fire(4'd6, 5'd0, 2'd0, 32'h2000, 1'b1, 1'b0, 0, 0, 32'h100);
    chk("R10", "ss depc no fix", depc_o, 32'h2000);
    chk("R10", "ss bit", db_o, 32'h101);
    chk("R12", "wr debug", {22'd0, wr_o}, 32'h349);
  endtask

  task automatic t_dbg();
    logic [31:0] exp_bit [4];
    exp_bit[0] = 32'h10; exp_bit[1] = 32'h02; exp_bit[2] = 32'h08; exp_bit[3] = 32'h04;
    for (int i = 0; i < 4; i++) begin
      fire(4'(8 + i), 5'd0, 2'd0, 32'h3000, 1'b1, 1'b0, 0, 0, 0);
      chk("R9", "debug class bit", db_o, exp_bit[i]);
      chk("R9", "debug depc", depc_o, 32'h2FFC);
      chk("R9", "debug vector", pc_o, 32'hBFC0_0480);
    end
  endtask

  task automatic t_ignore();
    logic [31:0] pc_b, epc_b, st_b;
    pc_b = pc_o; epc_b = epc_o; st_b = st_o;
    for (int c = 12; c < 16; c++) begin
      fire(4'(c), 5'd1, 2'd1, 32'hDEAD_0000, 1'b1, 1'b0, 32'h1, 32'h1, 32'h1);
      chk("R1", "unused class wr", {22'd0, wr_o}, 0);
      chk("R1", "unused class pc", pc_o, pc_b);
    end
    @(negedge clk);
    pc = 32'h7777_0000; st_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1", "hold epc", epc_o, epc_b);
    chk("R1", "hold status", st_o, st_b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gen_plain();
    t_gen_slot();
    t_wrap();
    t_cpu();
    t_int();
    t_int_dm();
    t_err();
    t_ss();
    t_dbg();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule